// File: doc/BRIEF.md
# Serial port register front end

This block is the software-visible face of a serial port. It holds a status word, a receive data word and five control words (a divisor word, a primary control word, two auxiliary control words and a guard word) behind a word-wide request/acknowledge bus. Bytes arriving from a receive byte stream land in the data word. Bytes that software writes to the data word leave on a transmit byte stream. Both streams use valid/ready handshakes. Serialisation, baud timing and parity live in other blocks; the divisor, auxiliary and guard words are storage only.

Three status flags are kept: receive-full (status bit 5), transmit-done (bit 6) and transmit-empty (bit 7). One level interrupt line is raised when any of these flags is set together with the enable bit at the same position in the primary control word. Writes to the status word follow two rules, chosen by the size of the written value. The transmit-empty flag is always held at one, because a data write that the transmit stream cannot take yet holds the bus until the stream accepts the byte.

Top module: `uart_regfile`

## Requirements
- R1: After reset the status word reads 0x000000C0, every other register reads zero, irq is low and rx_ready is high.
- R2: irq is high exactly when status bits [7:5] AND primary control bits [7:5] is nonzero, and it follows every change of either word.
- R3: rx_ready equals the inverse of status bit 5 (receive-full), and a byte is taken in a cycle with rx_valid and rx_ready both high.
- R4: A taken byte is written to the data word and sets status bit 5 only when primary control bit 13 (port enable) and bit 2 (receive enable) are both one; otherwise it is dropped and leaves both unchanged.
- R5: A read of the data word returns the stored byte in bits [9:0] with bits [31:10] zero, and clears status bit 5.
- R6: A status write of a value at most 0x3FF loads value[9:0] with bit 7 forced to one; a larger value is ANDed into the status word, with bit 7 still held at one, so bit 7 always reads one.
- R7: A data write of a value below 0xF000 drives tx_valid with tx_data equal to wdata[7:0]; bus_ack stays low until tx_ready is high, and the completed write sets status bit 6. A value of 0xF000 or more is acknowledged at once with no transmit and no state change.
- R8: The divisor, primary control, auxiliary and guard words read back the full 32-bit value last written.
- R9: Word offsets are status 0x00, data 0x04, divisor 0x08, primary control 0x0C, auxiliary 0x10 and 0x14, guard 0x18; bus_addr[1:0] is ignored; other offsets in the 10-bit window read zero and writes to them change nothing.
- R10: When a status write and a kept receive byte fall in the same cycle, the status write rule is applied first and the receive byte then sets bit 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus access request, held until bus_ack |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 10 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read is acknowledged |
| bus_ack | output | 1 | Access completes on a clock edge where bus_req and bus_ack are high |
| rx_valid | input | 1 | Receive stream byte present |
| rx_data | input | 8 | Receive stream byte |
| rx_ready | output | 1 | Receive stream can take a byte |
| tx_valid | output | 1 | Transmit stream byte present |
| tx_data | output | 8 | Transmit stream byte |
| tx_ready | input | 1 | Transmit stream takes the byte |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach from the ports is a status write landing in the same cycle as a receive byte that is kept, because the bus and the receive stream are normally driven one after the other. A directed task raises both handshakes on one edge, first with a small loading value and then with a large masking value that would clear bit 5, and then reads the status word back. Transmit stalls come from a tx_ready that is redrawn at random on every cycle of a data write, so the bench sees writes that are held for several cycles.

// File: rtl/ureg_pkg.sv
package ureg_pkg;
  localparam int WORD_W  = 32;
  localparam int STAT_W  = 10;
  localparam int NUM_CFG = 5;
  localparam int NUM_REG = 2 + NUM_CFG;

  localparam int IDX_STAT = 0;
  localparam int IDX_DATA = 1;
  localparam int IDX_CFG0 = 2;   // divisor, primary control, aux A, aux B, guard
  localparam int IDX_CTL1 = 3;

  localparam int FLAG_RXNE = 5;
  localparam int FLAG_TC   = 6;
  localparam int FLAG_TXE  = 7;
  localparam int CTL_RE    = 2;
  localparam int CTL_UE    = 13;

  localparam logic [STAT_W-1:0] STAT_RST   = 10'h0C0;
  localparam logic [WORD_W-1:0] LOAD_LIMIT = 32'h0000_03FF;
  localparam logic [WORD_W-1:0] TX_LIMIT   = 32'h0000_F000;
endpackage

// File: rtl/ureg_decode.sv
module ureg_decode
  import ureg_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_REG-1:0] sel
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             unused_low;

  assign idx        = addr[ADDR_W-1:2];
  assign unused_low = ^addr[1:0];

  for (genvar i = 0; i < NUM_REG; i++) begin : g_sel
    assign sel[i] = (idx == IDX_W'(i));
  end
endmodule

// File: rtl/ureg_cfg_bank.sv
module ureg_cfg_bank
  import ureg_pkg::*;
#(
  parameter int N = NUM_CFG,
  parameter int W = WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      wr_en,
  input  logic [W-1:0]      wdata,
  output logic [N-1:0][W-1:0] q
);
  for (genvar k = 0; k < N; k++) begin : g_word
    logic [W-1:0] d;

    always_comb begin
      d = q[k];
      if (wr_en[k]) d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q[k] <= '0;
      else if (wr_en[k]) q[k] <= d;
    end
  end
endmodule

// File: rtl/ureg_status.sv
module ureg_status
  import ureg_pkg::*;
#(
  parameter int RX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              data_rd,
  input  logic              tx_done,
  input  logic              rx_store,
  input  logic [RX_W-1:0]   rx_byte,
  output logic [STAT_W-1:0] stat_q,
  output logic [RX_W-1:0]   data_q
);
  logic [STAT_W-1:0] stat_d;
  logic [RX_W-1:0]   data_d;
  logic              stat_en;

  assign stat_en = stat_wr | data_rd | tx_done | rx_store;

  always_comb begin
    stat_d = stat_q;
    if (stat_wr) begin
      if (wdata <= LOAD_LIMIT) stat_d = wdata[STAT_W-1:0];
      else                     stat_d = stat_q & wdata[STAT_W-1:0];
    end
    if (data_rd)  stat_d[FLAG_RXNE] = 1'b0;
    if (tx_done)  stat_d[FLAG_TC]   = 1'b1;
    if (rx_store) stat_d[FLAG_RXNE] = 1'b1;
    stat_d[FLAG_TXE] = 1'b1;
  end

  always_comb begin
    data_d = data_q;
    if (rx_store) data_d = rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= STAT_RST;
    else if (stat_en) stat_q <= stat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        data_q <= '0;
    else if (rx_store) data_q <= data_d;
  end
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import ureg_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int RX_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_ack,
  input  logic              rx_valid,
  input  logic [RX_W-1:0]   rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  output logic              irq
);
  localparam int DATA_VIS = 10;

  logic [NUM_REG-1:0]            sel;
  logic [NUM_CFG-1:0]            cfg_wr;
  logic [NUM_CFG-1:0][WORD_W-1:0] cfg_q;
  logic [STAT_W-1:0]             sr_q;
  logic [RX_W-1:0]               dr_q;
  logic [WORD_W-1:0]             cr1_q;
  logic                          access;
  logic                          tx_req;
  logic                          stat_wr;
  logic                          data_rd;
  logic                          tx_done;
  logic                          rx_store;
  logic [WORD_W-1:0]             dr_word;

  ureg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign tx_req   = bus_req & bus_we & sel[IDX_DATA] & (bus_wdata < TX_LIMIT);
  assign bus_ack  = ~tx_req | tx_ready;
  assign access   = bus_req & bus_ack;
  assign tx_valid = tx_req;
  assign tx_data  = bus_wdata[7:0];
  assign tx_done  = tx_req & tx_ready;

  assign stat_wr  = access & bus_we & sel[IDX_STAT];
  assign data_rd  = access & ~bus_we & sel[IDX_DATA];

  for (genvar k = 0; k < NUM_CFG; k++) begin : g_cfg_wr
    assign cfg_wr[k] = access & bus_we & sel[IDX_CFG0 + k];
  end

  ureg_cfg_bank #(.N(NUM_CFG), .W(WORD_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (cfg_wr),
    .wdata (bus_wdata),
    .q     (cfg_q)
  );

  assign cr1_q    = cfg_q[IDX_CTL1 - IDX_CFG0];
  assign rx_ready = ~sr_q[FLAG_RXNE];
  assign rx_store = rx_valid & rx_ready & cr1_q[CTL_UE] & cr1_q[CTL_RE];

  ureg_status #(.RX_W(RX_W)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .stat_wr  (stat_wr),
    .wdata    (bus_wdata),
    .data_rd  (data_rd),
    .tx_done  (tx_done),
    .rx_store (rx_store),
    .rx_byte  (rx_data),
    .stat_q   (sr_q),
    .data_q   (dr_q)
  );

  always_comb begin
    dr_word = '0;
    dr_word[RX_W-1:0] = dr_q;
    dr_word[WORD_W-1:DATA_VIS] = '0;
  end

  always_comb begin
    bus_rdata = '0;
    if (sel[IDX_STAT]) bus_rdata = {{(WORD_W-STAT_W){1'b0}}, sr_q};
    if (sel[IDX_DATA]) bus_rdata = dr_word;
    for (int k = 0; k < NUM_CFG; k++) begin
      if (sel[IDX_CFG0 + k]) bus_rdata = cfg_q[k];
    end
  end

  assign irq = |(sr_q[FLAG_TXE:FLAG_RXNE] & cr1_q[FLAG_TXE:FLAG_RXNE]);
endmodule

// File: rtl/ureg_checker.sv
module ureg_checker
  import ureg_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic              bus_ack,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WORD_W-1:0] bus_rdata,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              irq,
  input logic [STAT_W-1:0] sr_q,
  input logic [WORD_W-1:0] cr1_q
);
  logic [ADDR_W-3:0] idx;
  assign idx = bus_addr[ADDR_W-1:2];

  a_r6_txe_held: assert property (@(posedge clk) disable iff (!rst_n)
    sr_q[FLAG_TXE]);

  a_r4_rx_kept: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready && cr1_q[CTL_UE] && cr1_q[CTL_RE] |=> !rx_ready);

  a_r4_rx_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready && !(cr1_q[CTL_UE] && cr1_q[CTL_RE]) && !(bus_req && bus_we)
    |=> rx_ready);

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_ack && !bus_we && idx == 1 && !rx_ready |=> rx_ready);

  a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_we && idx == 1 |-> bus_rdata[WORD_W-1:10] == '0);

  a_r7_tx_stall: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |-> !bus_ack);

  a_r7_tc_set: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> sr_q[FLAG_TC]);

  a_r2_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(irq) |-> $past((bus_req && bus_ack) || (rx_valid && rx_ready)));

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_we && idx > 6 |-> bus_rdata == '0);
endmodule

bind uart_regfile ureg_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_ack   (bus_ack),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .irq       (irq),
  .sr_q      (sr_q),
  .cr1_q     (cr1_q)
);

// File: tb/uart_regfile_test.sv
module uart_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_req, bus_we;
  logic [9:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_ack;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        rx_ready, tx_valid, tx_ready, irq;
  logic [7:0]  tx_data;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  logic [9:0]  m_sr;
  logic [7:0]  m_dr;
  logic [31:0] m_cfg [5];

  always #10 clk = ~clk;

  uart_regfile uut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input int idx);
    case (idx)
      0: return {22'b0, m_sr};
      1: return {24'b0, m_dr};
      2, 3, 4, 5, 6: return m_cfg[idx-2];
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit exp_irq();
    return |(m_sr[7:5] & m_cfg[1][7:5]);
  endfunction

  function automatic bit rx_kept();
    return m_cfg[1][13] && m_cfg[1][2];
  endfunction

  function automatic void model_write(input int idx, input logic [31:0] v);
    if (idx == 0) begin
      if (v <= 32'h3FF) m_sr = v[9:0];
      else              m_sr = m_sr & v[9:0];
      m_sr[7] = 1'b1;
    end else if (idx == 1) begin
      if (v < 32'hF000) m_sr[6] = 1'b1;
    end else if (idx >= 2 && idx <= 6) begin
      m_cfg[idx-2] = v;
    end
  endfunction

  task automatic check_flags(input string req);
    #1;
    check(irq == exp_irq(), {req, "/R2 irq"}, {31'b0, irq}, {31'b0, exp_irq()});
    check(rx_ready == !m_sr[5], {req, "/R3 rx_ready"}, {31'b0, rx_ready}, {31'b0, !m_sr[5]});
  endtask

  // Called just after a falling edge; returns just after the next falling edge.
  task automatic bus_op(input bit we, input int idx, input logic [31:0] wdata, output logic [31:0] rdata);
    bit fin = 0;
    bit etx;
    logic [31:0] e;
    bus_req = 1'b1; bus_we = we;
    bus_addr = {idx[7:0], 2'($urandom % 4)};
    bus_wdata = wdata;
    etx = we && idx == 1 && wdata < 32'hF000;
    e = exp_read(idx);
    rdata = '0;
    while (!fin) begin
      tx_ready = ($urandom % 3) != 0;
      #1;
      check(tx_valid == etx, "R7 tx_valid", {31'b0, tx_valid}, {31'b0, etx});
      if (etx) check(tx_data == wdata[7:0], "R7 tx_data", {24'b0, tx_data}, {24'b0, wdata[7:0]});
      check(bus_ack == (!etx || tx_ready), "R7 ack", {31'b0, bus_ack}, {31'b0, !etx || tx_ready});
      if (bus_ack) begin
        rdata = bus_rdata;
        fin = 1;
        if (!we) check(bus_rdata == e, $sformatf("R8/R9 read idx %0d", idx), bus_rdata, e);
      end
      @(negedge clk);
    end
    bus_req = 1'b0; tx_ready = 1'b0;
    if (we) model_write(idx, wdata);
    else if (idx == 1) m_sr[5] = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] b);
    bit took;
    rx_valid = 1'b1; rx_data = b;
    #1;
    check(rx_ready == !m_sr[5], "R3 ready before push", {31'b0, rx_ready}, {31'b0, !m_sr[5]});
    took = rx_ready;
    @(negedge clk);
    rx_valid = 1'b0;
    if (took && rx_kept()) begin m_dr = b; m_sr[5] = 1'b1; end
  endtask

  task automatic sr_write_with_rx(input logic [31:0] v, input logic [7:0] b);
    bit took;
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 10'h000; bus_wdata = v;
    rx_valid = 1'b1; rx_data = b;
    #1;
    took = rx_ready;
    @(negedge clk);
    bus_req = 1'b0; rx_valid = 1'b0;
    model_write(0, v);
    if (took && rx_kept()) begin m_dr = b; m_sr[5] = 1'b1; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'h1F2E3D4C));
    rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    rx_valid = 1'b0; rx_data = '0; tx_ready = 1'b0;
    m_sr = 10'h0C0; m_dr = '0;
    for (int k = 0; k < 5; k++) m_cfg[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check_flags("R1");
    for (int i = 0; i < 7; i++) begin
      bus_op(0, i, 0, rd);
      check(rd == (i == 0 ? 32'hC0 : 32'h0), "R1 reset value", rd, (i == 0 ? 32'hC0 : 32'h0));
    end

    // R4: receiver disabled drops the byte
    rx_push(8'h5A);
    bus_op(0, 1, 0, rd);
    check(rd == 32'h0, "R4 dropped byte", rd, 32'h0);
    check_flags("R4");

    // R4/R3/R5: enabled receive, full holds off a second byte
    bus_op(1, 3, 32'h0000_2004, rd);
    rx_push(8'hA5);
    check_flags("R3 full");
    rx_push(8'h3C);
    bus_op(0, 1, 0, rd);
    check(rd == 32'hA5, "R5 data read", rd, 32'hA5);
    check_flags("R5 clear");

    // R2: interrupt from each flag
    bus_op(1, 3, 32'h0000_2084, rd);
    check_flags("R2 txe");
    bus_op(1, 0, 32'h0000_0080, rd);
    bus_op(1, 3, 32'h0000_2044, rd);
    check_flags("R2 tc clear");
    bus_op(1, 1, 32'h0000_0177, rd);
    check_flags("R2 tc set");

    // R6: masking write keeps bit 7
    bus_op(1, 0, 32'hFFFF_FF3F, rd);
    bus_op(0, 0, 0, rd);
    check(rd == 32'h080, "R6 mask write", rd, 32'h080);
    bus_op(1, 0, 32'h0000_0000, rd);
    bus_op(0, 0, 0, rd);
    check(rd == 32'h080, "R6 load write", rd, 32'h080);

    // R7: large data write ignored
    bus_op(1, 1, 32'h0000_F000, rd);
    bus_op(0, 0, 0, rd);
    check(rd == 32'h080, "R7 ignored write", rd, 32'h080);

    // R9: unmapped offsets
    bus_op(1, 7, 32'hDEAD_BEEF, rd);
    bus_op(1, 255, 32'h1234_5678, rd);
    bus_op(0, 7, 0, rd);
    bus_op(0, 200, 0, rd);
    for (int i = 2; i < 7; i++) bus_op(0, i, 0, rd);

    // R10: status write and kept byte in one cycle
    bus_op(1, 3, 32'h0000_2024, rd);
    sr_write_with_rx(32'h0000_0000, 8'h81);
    bus_op(0, 0, 0, rd);
    check(rd[5] == 1'b1, "R10 small write with rx", rd, {rd[31:6], 1'b1, rd[4:0]});
    bus_op(0, 1, 0, rd);
    sr_write_with_rx(32'hFFFF_FFDF, 8'h42);
    bus_op(0, 0, 0, rd);
    check(rd == {22'b0, m_sr}, "R10 mask write with rx", rd, {22'b0, m_sr});
    check_flags("R10");

    // Random traffic
    for (int n = 0; n < 600; n++) begin
      int op = $urandom % 6;
      case (op)
        0: rx_push(8'($urandom));
        1: bus_op(0, ($urandom % 4 == 0) ? int'($urandom % 256) : int'($urandom % 7), 0, rd);
        2: bus_op(1, 2 + int'($urandom % 5), $urandom, rd);
        3: bus_op(1, 0, ($urandom % 2) ? ($urandom % 32'h400) : $urandom, rd);
        4: bus_op(1, 1, ($urandom % 2) ? ($urandom % 32'h10000) : $urandom, rd);
        default: bus_op(1, 3, ($urandom & 32'hFFFF_DF1B) | (($urandom % 4 != 0) ? 32'h2004 : 32'h0)
                        | (($urandom & 32'h7) << 5), rd);
      endcase
      check_flags("R2/R3 random");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule